// File: doc/BRIEF.md
# Four-Lane Three-Wire Audio Serializer

This block sends audio on four serial data lines that share one bit clock and one left/right clock. Each lane has its own small sample buffer. A producer pushes left/right sample pairs into the buffer, and the lane sends one pair per frame. A frame is 64 bit periods long. The first 32 bits carry the left slot and the last 32 bits carry the right slot, most significant bit first.

The bit period is derived from the system clock by a selectable ratio. Each lane has its own sample width and justification, its own enable and its own mute. Two further mute inputs silence every lane at once.

Lanes start and stop only at a frame boundary. Lanes enabled together therefore run in lockstep, and no frame is ever cut short. Each lane signals when its buffer has just drained. It also signals when a frame begins with nothing to send.

Top module: `tw_audio_serializer`

## Requirements
- R1: `div_code` selects the bit period in system clock cycles: code 1 gives 2, code 2 gives 4, code 4 gives 8 and code 6 gives 12. Every other code gives 2. `bclk` is low for the first half of each bit period and high for the second half.
- R2: A frame is 64 bit periods. `lrck` is low for the 32 left-slot bits and high for the 32 right-slot bits. Each slot is sent most significant bit first, and each bit holds for one whole bit period.
- R3: `lane_wcode` (2 bits per lane) picks the sample width: 0 gives 16 bits, 2 gives 20 bits and 3 gives 24 bits. The reserved code 1 acts as 16 bits. The low bits of the 24-bit sample are used. With `lane_msb`=0 they sit at the low end of the 32-bit slot; with `lane_msb`=1 they sit at the top. All other slot bits are 0.
- R4: A lane's `lane_en` takes effect only at a frame boundary. `running` rises and falls only together with the falling edge of `lrck`. Lanes enabled together send identical frame timing. A lane that is not running outputs 0.
- R5: A lane sends zeros when its own `lane_mute`, `mute_serial_all` or `mute_all` is set. A muted lane still takes one sample pair from its buffer per frame.
- R6: `ev_empty[n]` pulses for one cycle at a frame start when the pair taken leaves lane n's buffer holding nothing.
- R7: If a running lane has an empty buffer at a frame start, `ev_underflow[n]` pulses for one cycle and that whole frame is zeros.
- R8: A one-cycle pulse on `buf_flush[n]` discards every sample pair held for lane n.
- R9: While `bclk_off` is 1, `bclk` stays 0. While `lrck_off` is 1, `lrck` stays 0.
- R10: Each buffer holds DEPTH pairs (default 4). `wr_ready[n]` is 0 while it is full, and a push made while full is dropped.
- R11: After reset no lane runs, every `sdata` bit is 0, no event is raised and every `wr_ready` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_code | input | 4 | Bit period select |
| bclk_off | input | 1 | Holds the bit clock output low |
| lrck_off | input | 1 | Holds the left/right clock output low |
| lane_en | input | LANES | Per-lane enable |
| lane_wcode | input | 2*LANES | Per-lane sample width code |
| lane_msb | input | LANES | Per-lane justification, 1 places data at the top of the slot |
| lane_mute | input | LANES | Per-lane mute |
| mute_serial_all | input | 1 | Mutes every serial lane |
| mute_all | input | 1 | Mutes every audio output |
| buf_flush | input | LANES | Per-lane buffer discard pulse |
| wr_valid | input | LANES | Per-lane push strobe |
| wr_left | input | 24*LANES | Left samples, lane n at bits 24n+23:24n |
| wr_right | input | 24*LANES | Right samples, same packing |
| wr_ready | output | LANES | Buffer has room |
| bclk | output | 1 | Bit clock |
| lrck | output | 1 | Left/right clock |
| sdata | output | LANES | Serial data per lane |
| running | output | LANES | Lane is sending frames |
| ev_empty | output | LANES | Buffer drained pulse |
| ev_underflow | output | LANES | Frame started with no sample pulse |

## Verification
Serial bits change on the system clock edge that ends a bit period, which is also where `bclk` falls. The bench samples `sdata` and `lrck` at each rising edge of `bclk`, half a bit period after the change. That rising edge falls a whole number of cycles away from any data change. `running`, `ev_empty` and `ev_underflow` change on the edge that starts a frame, so the bench compares them with `lrck` in the same sampled cycle. `wr_ready` is checked one cycle after the last push. All sampling happens on the falling edge of the system clock.

// File: rtl/tw_audio_pkg.sv
package tw_audio_pkg;
  localparam int SLOT_W     = 32;
  localparam int SAMP_W     = 24;
  localparam int FRAME_BITS = 2 * SLOT_W;
  localparam int MAX_RATIO  = 12;

  // bit period in system clock cycles for a divide code
  function automatic int unsigned bit_ratio(input logic [3:0] code);
    case (code)
      4'd2:    return 4;
      4'd4:    return 8;
      4'd6:    return 12;
      default: return 2;
    endcase
  endfunction

  // place a sample of the coded width at the low or high end of a slot
  function automatic logic [SLOT_W-1:0] place_sample(input logic [SAMP_W-1:0] s,
                                                     input logic [1:0] wcode,
                                                     input logic msb_side);
    logic [SLOT_W-1:0] v;
    case (wcode)
      2'd2:    v = {12'd0, s[19:0]};
      2'd3:    v = {8'd0, s};
      default: v = {16'd0, s[15:0]};
    endcase
    if (msb_side) begin
      case (wcode)
        2'd2:    v = v << 12;
        2'd3:    v = v << 8;
        default: v = v << 16;
      endcase
    end
    return v;
  endfunction
endpackage

// File: rtl/tw_bitclk_gen.sv
module tw_bitclk_gen
  import tw_audio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] div_code,
  output logic       tick,
  output logic       fstart,
  output logic       bclk_raw,
  output logic       lr_raw
);
  localparam int CNT_W = $clog2(MAX_RATIO);
  localparam int IDX_W = $clog2(FRAME_BITS);

  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] bidx_q;
  int unsigned      ratio;

  assign ratio    = bit_ratio(div_code);
  assign tick     = (cnt_q >= CNT_W'(ratio - 1));
  assign fstart   = tick && (bidx_q == IDX_W'(FRAME_BITS - 1));
  assign bclk_raw = (cnt_q >= CNT_W'(ratio / 2));
  assign lr_raw   = bidx_q[IDX_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bidx_q <= '0;
    end else if (tick) begin
      cnt_q  <= '0;
      bidx_q <= bidx_q + 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // every ratio is at least two cycles, so bit ends never sit back to back
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick);
endmodule

// File: rtl/tw_pair_fifo.sv
module tw_pair_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         last_one
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CW'(DEPTH));
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign head     = mem[rp_q];
  assign last_one = (cnt_q == CW'(1)) && !do_push;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else if (flush) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= bump(wp_q);
      if (do_pop)  rp_q <= bump(rp_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> full);
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/tw_lane.sv
module tw_lane
  import tw_audio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              fstart,
  input  logic              enable,
  input  logic              mute,
  input  logic [1:0]        wcode,
  input  logic              msb_side,
  input  logic [2*SAMP_W-1:0] head,
  input  logic              empty,
  input  logic              last_one,
  output logic              pop,
  output logic              sd,
  output logic              running,
  output logic              ev_empty,
  output logic              ev_underflow
);
  logic [FRAME_BITS-1:0] sh_q;

  assign pop = fstart && enable && !empty;
  assign sd  = sh_q[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; running <= 1'b0; ev_empty <= 1'b0; ev_underflow <= 1'b0;
    end else begin
      ev_empty     <= 1'b0;
      ev_underflow <= 1'b0;
      if (fstart) begin
        running <= enable;
        if (pop) begin
          sh_q     <= mute ? '0 : {place_sample(head[2*SAMP_W-1:SAMP_W], wcode, msb_side),
                                   place_sample(head[SAMP_W-1:0], wcode, msb_side)};
          ev_empty <= last_one;
        end else begin
          sh_q         <= '0;
          ev_underflow <= enable;
        end
      end else if (tick) begin
        sh_q <= sh_q << 1;
      end
    end
  end

  p_run_at_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(running) |-> $past(fstart));
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n) !running |-> !sd);
  p_uf_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_underflow |-> (sh_q == '0));
  p_one_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_empty && ev_underflow));
endmodule

// File: rtl/tw_audio_serializer.sv
module tw_audio_serializer
  import tw_audio_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3:0]            div_code,
  input  logic                  bclk_off,
  input  logic                  lrck_off,
  input  logic [LANES-1:0]      lane_en,
  input  logic [2*LANES-1:0]    lane_wcode,
  input  logic [LANES-1:0]      lane_msb,
  input  logic [LANES-1:0]      lane_mute,
  input  logic                  mute_serial_all,
  input  logic                  mute_all,
  input  logic [LANES-1:0]      buf_flush,
  input  logic [LANES-1:0]      wr_valid,
  input  logic [SAMP_W*LANES-1:0] wr_left,
  input  logic [SAMP_W*LANES-1:0] wr_right,
  output logic [LANES-1:0]      wr_ready,
  output logic                  bclk,
  output logic                  lrck,
  output logic [LANES-1:0]      sdata,
  output logic [LANES-1:0]      running,
  output logic [LANES-1:0]      ev_empty,
  output logic [LANES-1:0]      ev_underflow
);
  logic tick, fstart, bclk_raw, lr_raw;

  tw_bitclk_gen u_clk (
    .clk(clk), .rst_n(rst_n), .div_code(div_code),
    .tick(tick), .fstart(fstart), .bclk_raw(bclk_raw), .lr_raw(lr_raw)
  );

  assign bclk = bclk_raw && !bclk_off;
  assign lrck = lr_raw && !lrck_off;

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    logic [2*SAMP_W-1:0] head;
    logic empty, full, last_one, pop;

    tw_pair_fifo #(.DEPTH(DEPTH), .W(2*SAMP_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .flush(buf_flush[n]), .push(wr_valid[n]),
      .din({wr_left[n*SAMP_W +: SAMP_W], wr_right[n*SAMP_W +: SAMP_W]}),
      .pop(pop), .head(head), .empty(empty), .full(full), .last_one(last_one)
    );
    assign wr_ready[n] = !full;

    tw_lane u_lane (
      .clk(clk), .rst_n(rst_n), .tick(tick), .fstart(fstart), .enable(lane_en[n]),
      .mute(lane_mute[n] || mute_serial_all || mute_all),
      .wcode(lane_wcode[2*n +: 2]), .msb_side(lane_msb[n]),
      .head(head), .empty(empty), .last_one(last_one),
      .pop(pop), .sd(sdata[n]), .running(running[n]),
      .ev_empty(ev_empty[n]), .ev_underflow(ev_underflow[n])
    );
  end
endmodule

// File: tb/tw_audio_serializer_tb_top.sv
module tw_audio_serializer_tb_top;
  localparam int L = 4;
  localparam int D = 4;

  logic clk = 0, rst_n = 0;
  logic [3:0] div_code = 4'd1;
  logic bclk_off = 1, lrck_off = 1;
  logic [L-1:0] lane_en = 0, lane_msb = 0, lane_mute = 0, buf_flush = 0, wr_valid = 0;
  logic [2*L-1:0] lane_wcode = 0;
  logic mute_serial_all = 0, mute_all = 0;
  logic [24*L-1:0] wr_left = 0, wr_right = 0;
  logic [L-1:0] wr_ready, sdata, running, ev_empty, ev_underflow;
  logic bclk, lrck;

  tw_audio_serializer #(.LANES(L), .DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .div_code(div_code), .bclk_off(bclk_off), .lrck_off(lrck_off),
    .lane_en(lane_en), .lane_wcode(lane_wcode), .lane_msb(lane_msb), .lane_mute(lane_mute),
    .mute_serial_all(mute_serial_all), .mute_all(mute_all), .buf_flush(buf_flush),
    .wr_valid(wr_valid), .wr_left(wr_left), .wr_right(wr_right), .wr_ready(wr_ready),
    .bclk(bclk), .lrck(lrck), .sdata(sdata), .running(running),
    .ev_empty(ev_empty), .ev_underflow(ev_underflow)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic [3:0] dv; logic [1:0] w; logic m; logic [3:0] ratio;
    logic [23:0] l; logic [23:0] r; logic [31:0] el; logic [31:0] er;
  } vec_t;
  localparam vec_t VEC [7] = '{
    '{4'd1, 2'd0, 1'b0, 4'd2,  24'h00ABCD, 24'h001234, 32'h0000ABCD, 32'h00001234},
    '{4'd2, 2'd2, 1'b1, 4'd4,  24'h0ABCDE, 24'h012345, 32'hABCDE000, 32'h12345000},
    '{4'd4, 2'd3, 1'b0, 4'd8,  24'hA5C3F0, 24'h123456, 32'h00A5C3F0, 32'h00123456},
    '{4'd6, 2'd3, 1'b1, 4'd12, 24'h800001, 24'hFFFFFF, 32'h80000100, 32'hFFFFFF00},
    '{4'd1, 2'd2, 1'b0, 4'd2,  24'hF0ABCD, 24'h0FFFFF, 32'h0000ABCD, 32'h000FFFFF},
    '{4'd1, 2'd0, 1'b1, 4'd2,  24'h12BEEF, 24'h000001, 32'hBEEF0000, 32'h00010000},
    '{4'd9, 2'd1, 1'b0, 4'd2,  24'h005A5A, 24'hFFA5A5, 32'h00005A5A, 32'h0000A5A5}
  };

  int total = 0, bad = 0, cyc = 0, last_rise = 0, period = 0, bound_bad = 0;
  bit done = 0;
  int pos [L]; bit capt [L]; logic [63:0] acc [L]; logic [63:0] rxf [L][8]; int rxn [L];
  int n_empty [L]; int n_uf [L];
  logic prev_b = 0, prev_lr = 0, lr_cap_prev = 0;
  logic [L-1:0] prev_run = 0;

  initial for (int n = 0; n < L; n++) begin
    pos[n] = 64; capt[n] = 0; acc[n] = 0; rxn[n] = 0; n_empty[n] = 0; n_uf[n] = 0;
  end

  // receiver: samples data at each bclk rise, collects frames of running lanes
  always @(negedge clk) begin
    cyc++;
    for (int n = 0; n < L; n++) begin
      if (ev_empty[n]) n_empty[n]++;
      if (ev_underflow[n]) n_uf[n]++;
      if (!lrck_off && running[n] != prev_run[n] && !(prev_lr && !lrck)) bound_bad++;
    end
    if (bclk && !prev_b) begin
      period = cyc - last_rise; last_rise = cyc;
      for (int n = 0; n < L; n++) begin
        if (!lrck && lr_cap_prev) begin pos[n] = 0; capt[n] = running[n]; end
        if (pos[n] < 64) begin
          acc[n][63-pos[n]] = sdata[n];
          pos[n]++;
          if (pos[n] == 64 && capt[n] && rxn[n] < 8) begin rxf[n][rxn[n]] = acc[n]; rxn[n]++; end
        end
      end
      lr_cap_prev = lrck;
    end
    prev_b = bclk; prev_lr = lrck; prev_run = running;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  function automatic logic [31:0] exp_slot(input logic [23:0] s, input logic [1:0] w, input logic m);
    int bits; logic [31:0] v;
    bits = (w == 2'd2) ? 20 : (w == 2'd3) ? 24 : 16;
    v = {8'd0, s} & ((32'd1 << bits) - 32'd1);
    if (m) v = v << (32 - bits);
    return v;
  endfunction

  task automatic clear_rx();
    for (int n = 0; n < L; n++) begin rxn[n] = 0; n_empty[n] = 0; n_uf[n] = 0; end
  endtask

  task automatic push(input logic [L-1:0] which, input logic [23:0] lv, input logic [23:0] rv);
    @(negedge clk);
    wr_valid = which;
    for (int n = 0; n < L; n++) begin wr_left[n*24 +: 24] = lv; wr_right[n*24 +: 24] = rv; end
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic wait_rx(input int ch, input int k, input string req);
    int lim = 0;
    while (rxn[ch] < k && lim < 6000) begin @(negedge clk); lim++; end
    chk(rxn[ch] >= k, req, 64'(rxn[ch]), 64'(k));
  endtask

  task automatic go_idle();
    int lim = 0;
    lane_en = 0;
    while (running != 0 && lim < 3000) begin @(negedge clk); lim++; end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R11 reset state, R9 clocks held while disabled
    chk(running == 0 && sdata == 0 && ev_empty == 0 && ev_underflow == 0, "R11", {running, sdata}, 0);
    chk(wr_ready == 4'hF, "R11 ready", 64'(wr_ready), 64'hF);
    begin
      int hb = 0, hl = 0;
      repeat (300) begin @(negedge clk); hb += bclk; hl += lrck; end
      chk(hb == 0 && hl == 0, "R9 held", 64'(hb + hl), 0);
    end
    bclk_off = 0; lrck_off = 0;
    begin
      int hb = 0;
      repeat (8) begin @(negedge clk); hb += bclk; end
      chk(hb == 4, "R9 released", 64'(hb), 4);
    end

    // table: R1 R2 R3 R4 R6 R7
    foreach (VEC[i]) begin
      go_idle();
      div_code = VEC[i].dv;
      lane_wcode = {L{VEC[i].w}};
      lane_msb = {L{VEC[i].m}};
      clear_rx();
      push(4'hF, VEC[i].l, VEC[i].r);
      lane_en = 4'hF;
      wait_rx(0, 2, "R4 start");
      for (int n = 0; n < L; n++) begin
        chk(rxf[n][0] == {VEC[i].el, VEC[i].er}, "R3 R2 R4 frame", rxf[n][0], {VEC[i].el, VEC[i].er});
        chk(rxf[n][1] == 0, "R7 zero frame", rxf[n][1], 0);
        chk(n_empty[n] == 1, "R6", 64'(n_empty[n]), 1);
        chk(n_uf[n] >= 1, "R7 event", 64'(n_uf[n]), 1);
      end
      chk(period == int'(VEC[i].ratio), "R1 period", 64'(period), 64'(VEC[i].ratio));
    end

    // R5 mute layers
    go_idle();
    div_code = 4'd1; lane_wcode = {L{2'd3}}; lane_msb = 0;
    for (int k = 0; k < 3; k++) begin
      go_idle();
      lane_mute = (k == 0) ? 4'b0010 : 4'b0000;
      mute_serial_all = (k == 1);
      mute_all = (k == 2);
      clear_rx();
      push(4'hF, 24'hC0FFEE, 24'h00BEAD);
      lane_en = 4'hF;
      wait_rx(3, 1, "R5 start");
      for (int n = 0; n < L; n++) begin
        logic [63:0] e;
        e = (k == 0 && n != 1) ? {exp_slot(24'hC0FFEE, 2'd3, 1'b0), exp_slot(24'h00BEAD, 2'd3, 1'b0)} : 64'd0;
        chk(rxf[n][0] == e, "R5 mute", rxf[n][0], e);
        chk(n_empty[n] == 1, "R5 consumed", 64'(n_empty[n]), 1);
      end
    end
    go_idle();
    lane_mute = 0; mute_serial_all = 0; mute_all = 0;

    // R8 flush, single lane enabled alone
    clear_rx();
    push(4'b0100, 24'h111111, 24'h222222);
    push(4'b0100, 24'h333333, 24'h444444);
    @(negedge clk); buf_flush = 4'b0100; @(negedge clk); buf_flush = 0;
    lane_en = 4'b0100;
    wait_rx(2, 1, "R8 start");
    chk(rxf[2][0] == 0, "R8 flushed", rxf[2][0], 0);
    chk(n_uf[2] >= 1 && n_empty[2] == 0, "R8 events", 64'(n_uf[2]), 1);
    chk(rxn[0] == 0, "R4 other lane idle", 64'(rxn[0]), 0);
    go_idle();

    // R10 full buffer drops extra push
    clear_rx();
    for (int k = 0; k < D; k++) push(4'b1000, 24'h100000 + 24'(k), 24'(k));
    chk(wr_ready[3] == 0, "R10 full", 64'(wr_ready), 64'h7);
    push(4'b1000, 24'hEEEEEE, 24'hEEEEEE);
    lane_en = 4'b1000;
    wait_rx(3, D + 1, "R10 drain");
    for (int k = 0; k < D; k++)
      chk(rxf[3][k] == {32'h00100000 + 32'(k), 32'(k)}, "R10 order", rxf[3][k], {32'h00100000 + 32'(k), 32'(k)});
    chk(rxf[3][D] == 0, "R10 dropped", rxf[3][D], 0);
    go_idle();
    chk(running == 0 && sdata == 0, "R4 stopped", {running, sdata}, 0);
    chk(bound_bad == 0, "R4 boundary", 64'(bound_bad), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule